// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block turns architectural register numbers into physical register indices for a 128-entry general register file and a 64-entry file of one-bit predicates. The low part of each file is static: those numbers are used as physical indices without change. The upper part can rotate. A rotating base moves by one step each time the loop-closing branch asserts the rotate strobe, so each loop iteration sees a shifted window of physical registers. A value written in one iteration through r32 is reached as r33 in the next iteration. Software sets the size of the general rotating region. The predicate rotating region has a fixed size.

The block holds the predicate file itself. Predicate 0 always reads true and cannot be written. The qualifying predicate of an instruction decides whether its general register write is committed and whether a predicate write takes effect. All index mapping is combinational. The two rotating bases and the predicate bits change only on the rising clock edge.

Top module: `rr_rename`

## Requirements
- R1: A general register number below 32 gives a physical index equal to that number, whatever the base and size.
- R2: The effective size S is `gr_size` limited to 96. For a general number a with 32 <= a < 32+S, the physical index is 32 + ((a - 32 + B) mod S), where B is the effective base. A number at or above 32+S passes through unchanged.
- R3: Each rotate strobe moves the general base down by one modulo S, so the physical index of r33 after a step equals the physical index of r32 before it. A stored base that is not below S counts as base 0. After a step from it, the base is S-1.
- R4: When S is 0, every general number passes through unchanged and rotate leaves the base at 0.
- R5: `clr` sets both rotating bases to 0 on the next edge, so the mapping becomes identity. It takes priority over a rotate in the same cycle.
- R6: Predicates 0 to 15 are static. Predicates 16 to 63 form a rotating region of fixed size 48 that steps with the same strobe, using the R2/R3 rule with base 16.
- R7: Predicate 0 reads as 1 on both read ports. A write to it has no effect.
- R8: `gr_wr_commit` is 1 only when `gr_wr_req` is 1 and the qualifying predicate reads 1. A predicate write is stored only when the qualifying predicate reads 1. Otherwise the target predicate keeps its value.
- R9: A write and a rotate in the same cycle both use the mapping from before the rotate.
- R10: After reset, both bases are 0 and predicates 1 to 63 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Reset both rotating bases to 0 |
| rotate | input | 1 | One rotation step per loop iteration |
| gr_size | input | 7 | Size of the general rotating region (limited to 96) |
| gr_rd_arch | input | 14 | Two packed 7-bit architectural read numbers |
| gr_rd_phys | output | 14 | Two packed 7-bit physical read indices |
| gr_wr_arch | input | 7 | Architectural destination number |
| gr_wr_phys | output | 7 | Physical destination index |
| gr_wr_req | input | 1 | Instruction wants to write its destination |
| gr_wr_commit | output | 1 | Destination write is committed |
| qp_arch | input | 6 | Qualifying predicate number |
| qp_val | output | 1 | Qualifying predicate value |
| pr_rd_arch | input | 6 | Predicate read number |
| pr_rd_val | output | 1 | Predicate read value |
| pw_en | input | 1 | Predicate write request |
| pw_arch | input | 6 | Predicate write number |
| pw_data | input | 1 | Predicate write value |

## Verification
A wrong base shows at once as a wrong physical index for every number inside the rotating region. A base that is off by one after a strobe is seen on the first sweep that follows that edge. Wrong predicate state shows on the next read of the affected number. A write that lands through a stale or early mapping shows one cycle later, as the value appearing under the wrong neighbouring number. A wrap error in the modulo step appears only after S strobes, so the sweeps run each size through more than one full rotation.

// File: rtl/rr_pkg.sv
package rr_pkg;

   // Next stored base after one rotation step, downward with wrap.
   function automatic logic [7:0] rot_step(input logic [7:0] base, input logic [7:0] size);
      logic [7:0] nxt;
      if (size == 8'd0)
         nxt = 8'd0;
      else if (base == 8'd0 || base >= size)
         nxt = size - 8'd1;
      else
         nxt = base - 8'd1;
      return nxt;
   endfunction

   // A stored base outside the current region counts as zero.
   function automatic logic [7:0] eff_base(input logic [7:0] base, input logic [7:0] size);
      return (base >= size) ? 8'd0 : base;
   endfunction

endpackage

// File: rtl/rr_base_ctr.sv
module rr_base_ctr
   import rr_pkg::*;
#(
   parameter int unsigned BW = 7
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rotate,
   input  logic [BW-1:0] size,
   output logic [BW-1:0] base_eff
);

   logic [BW-1:0] base_q;
   logic [7:0]    nxt8;
   logic [7:0]    eff8;

   generate
      if (BW > 8) begin : g_bad_width
         $error("rr_base_ctr: BW above 8 is not supported");
      end
   endgenerate

   always_comb begin
      nxt8 = rot_step(8'(base_q), 8'(size));
      eff8 = eff_base(8'(base_q), 8'(size));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (clr)
         base_q <= '0;
      else if (rotate)
         base_q <= BW'(nxt8);
   end

   assign base_eff = BW'(eff8);

endmodule

// File: rtl/rr_map.sv
module rr_map #(
   parameter int unsigned IW     = 7,
   parameter int unsigned STATIC = 32,
   parameter int unsigned BW     = 7
)(
   input  logic [IW-1:0] arch,
   input  logic [BW-1:0] size,
   input  logic [BW-1:0] base,
   output logic [IW-1:0] phys
);

   localparam int unsigned SW = ((IW > BW) ? IW : BW) + 1;

   logic [SW-1:0] off;
   logic          above;
   logic          in_rgn;
   logic [SW-1:0] sum;
   logic [SW-1:0] wrapped;

   generate
      if (STATIC == 0) begin : g_no_static
         assign off   = SW'(arch);
         assign above = 1'b1;
      end else begin : g_static
         assign off   = SW'(arch) - SW'(STATIC);
         assign above = (arch >= IW'(STATIC));
      end
   endgenerate

   always_comb begin
      in_rgn  = above && (size != '0) && (off < SW'(size));
      sum     = off + SW'(base);
      wrapped = (sum >= SW'(size)) ? (sum - SW'(size)) : sum;
      phys    = in_rgn ? IW'(wrapped + SW'(STATIC)) : arch;
   end

endmodule

// File: rtl/rr_pred_file.sv
module rr_pred_file #(
   parameter int unsigned PN = 64,
   parameter int unsigned NR = 2,
   localparam int unsigned PIW = $clog2(PN)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PIW-1:0]  wr_idx,
   input  logic            wr_data,
   input  logic [NR*PIW-1:0] rd_idx,
   output logic [NR-1:0]   rd_val
);

   logic [PN-1:1] bits_q;
   logic [PN-1:0] file_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bits_q <= '0;
      else if (wr_en && wr_idx != '0)
         bits_q[wr_idx] <= wr_data;
   end

   assign file_v = {bits_q, 1'b1};

   generate
      for (genvar r = 0; r < NR; r++) begin : g_rd
         assign rd_val[r] = file_v[rd_idx[r*PIW +: PIW]];
      end
   endgenerate

endmodule

// File: rtl/rr_rename.sv
module rr_rename #(
   parameter int unsigned GR_COUNT  = 128,
   parameter int unsigned GR_STATIC = 32,
   parameter int unsigned PR_COUNT  = 64,
   parameter int unsigned PR_STATIC = 16,
   parameter int unsigned NRD       = 2,
   localparam int unsigned GRW    = $clog2(GR_COUNT),
   localparam int unsigned PRW    = $clog2(PR_COUNT),
   localparam int unsigned GR_ROT = GR_COUNT - GR_STATIC,
   localparam int unsigned GSW    = $clog2(GR_ROT + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               rotate,
   input  logic [GSW-1:0]     gr_size,
   input  logic [NRD*GRW-1:0] gr_rd_arch,
   output logic [NRD*GRW-1:0] gr_rd_phys,
   input  logic [GRW-1:0]     gr_wr_arch,
   output logic [GRW-1:0]     gr_wr_phys,
   input  logic               gr_wr_req,
   output logic               gr_wr_commit,
   input  logic [PRW-1:0]     qp_arch,
   output logic               qp_val,
   input  logic [PRW-1:0]     pr_rd_arch,
   output logic               pr_rd_val,
   input  logic               pw_en,
   input  logic [PRW-1:0]     pw_arch,
   input  logic               pw_data
);

   localparam int unsigned PR_ROT = PR_COUNT - PR_STATIC;
   localparam int unsigned PSW    = $clog2(PR_ROT + 1);

   generate
      if (GR_STATIC >= GR_COUNT) begin : g_bad_gr
         $error("rr_rename: GR_STATIC must be below GR_COUNT");
      end
      if (PR_STATIC >= PR_COUNT || PR_STATIC == 0) begin : g_bad_pr
         $error("rr_rename: PR_STATIC must be in 1..PR_COUNT-1");
      end
      if (NRD == 0) begin : g_bad_nrd
         $error("rr_rename: NRD must be at least 1");
      end
   endgenerate

   logic [GSW-1:0] gsz_eff;
   logic [GSW-1:0] gbase;
   logic [PSW-1:0] pbase;
   logic [PSW-1:0] psz;
   logic [PRW-1:0] qp_phys;
   logic [PRW-1:0] prd_phys;
   logic [PRW-1:0] pw_phys;
   logic [1:0]     prd_val;
   logic           pw_commit;

   assign gsz_eff = (gr_size > GSW'(GR_ROT)) ? GSW'(GR_ROT) : gr_size;
   assign psz     = PSW'(PR_ROT);

   rr_base_ctr #(.BW(GSW)) u_gbase (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rotate(rotate),
      .size(gsz_eff), .base_eff(gbase)
   );

   rr_base_ctr #(.BW(PSW)) u_pbase (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rotate(rotate),
      .size(psz), .base_eff(pbase)
   );

   generate
      for (genvar i = 0; i < NRD; i++) begin : g_gr_rd
         rr_map #(.IW(GRW), .STATIC(GR_STATIC), .BW(GSW)) u_map (
            .arch(gr_rd_arch[i*GRW +: GRW]), .size(gsz_eff), .base(gbase),
            .phys(gr_rd_phys[i*GRW +: GRW])
         );
      end
   endgenerate

   rr_map #(.IW(GRW), .STATIC(GR_STATIC), .BW(GSW)) u_map_gw (
      .arch(gr_wr_arch), .size(gsz_eff), .base(gbase), .phys(gr_wr_phys)
   );

   rr_map #(.IW(PRW), .STATIC(PR_STATIC), .BW(PSW)) u_map_qp (
      .arch(qp_arch), .size(psz), .base(pbase), .phys(qp_phys)
   );

   rr_map #(.IW(PRW), .STATIC(PR_STATIC), .BW(PSW)) u_map_pr (
      .arch(pr_rd_arch), .size(psz), .base(pbase), .phys(prd_phys)
   );

   rr_map #(.IW(PRW), .STATIC(PR_STATIC), .BW(PSW)) u_map_pw (
      .arch(pw_arch), .size(psz), .base(pbase), .phys(pw_phys)
   );

   rr_pred_file #(.PN(PR_COUNT), .NR(2)) u_pfile (
      .clk(clk), .rst_n(rst_n),
      .wr_en(pw_commit), .wr_idx(pw_phys), .wr_data(pw_data),
      .rd_idx({prd_phys, qp_phys}), .rd_val(prd_val)
   );

   assign qp_val       = prd_val[0];
   assign pr_rd_val    = prd_val[1];
   assign pw_commit    = pw_en & qp_val;
   assign gr_wr_commit = gr_wr_req & qp_val;

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
   parameter int unsigned GR_STATIC = 32,
   parameter int unsigned GR_ROT    = 96,
   parameter int unsigned GRW       = 7,
   parameter int unsigned GSW       = 7,
   parameter int unsigned PRW       = 6
)(
   input logic           clk,
   input logic           rst_n,
   input logic           clr,
   input logic           rotate,
   input logic [GSW-1:0] gr_size,
   input logic [GRW-1:0] gr_wr_arch,
   input logic [GRW-1:0] gr_wr_phys,
   input logic           gr_wr_req,
   input logic           gr_wr_commit,
   input logic [PRW-1:0] qp_arch,
   input logic           qp_val,
   input logic [PRW-1:0] pr_rd_arch,
   input logic           pr_rd_val,
   input logic           pw_en,
   input logic [PRW-1:0] pw_arch
);

   logic [8:0] es;
   assign es = (9'(gr_size) > 9'(GR_ROT)) ? 9'(GR_ROT) : 9'(gr_size);

   p_static_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gr_wr_arch < GRW'(GR_STATIC)) |-> (gr_wr_phys == gr_wr_arch));

   p_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (9'(gr_wr_arch) >= 9'(GR_STATIC) && 9'(gr_wr_arch) < 9'(GR_STATIC) + es)
      |-> (9'(gr_wr_phys) >= 9'(GR_STATIC) && 9'(gr_wr_phys) < 9'(GR_STATIC) + es));

   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rotate) && !$past(clr) && $stable(gr_size) && es >= 9'd2 &&
       $past(gr_wr_arch) == GRW'(GR_STATIC) && gr_wr_arch == GRW'(GR_STATIC + 1))
      |-> (gr_wr_phys == $past(gr_wr_phys)));

   p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gr_size == '0) |-> (gr_wr_phys == gr_wr_arch));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (gr_wr_phys == gr_wr_arch));

   p_true_qp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (qp_arch == '0) |-> qp_val);

   p_true_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_rd_arch == '0) |-> pr_rd_val);

   p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gr_wr_commit |-> (gr_wr_req && qp_val));

   p_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pw_en) && !$past(qp_val) && !$past(rotate) && !$past(clr) &&
       $stable(pr_rd_arch) && pr_rd_arch == $past(pw_arch))
      |-> $stable(pr_rd_val));

endmodule

bind rr_rename rr_checker #(
   .GR_STATIC(GR_STATIC), .GR_ROT(GR_ROT), .GRW(GRW), .GSW(GSW), .PRW(PRW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .rotate(rotate), .gr_size(gr_size),
   .gr_wr_arch(gr_wr_arch), .gr_wr_phys(gr_wr_phys), .gr_wr_req(gr_wr_req),
   .gr_wr_commit(gr_wr_commit), .qp_arch(qp_arch), .qp_val(qp_val),
   .pr_rd_arch(pr_rd_arch), .pr_rd_val(pr_rd_val), .pw_en(pw_en), .pw_arch(pw_arch)
);

// File: tb/tb_rr_rename.sv
module tb_rr_rename;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        rotate = 1'b0;
   logic [6:0]  gr_size = 7'd96;
   logic [13:0] gr_rd_arch = '0;
   logic [13:0] gr_rd_phys;
   logic [6:0]  gr_wr_arch = '0;
   logic [6:0]  gr_wr_phys;
   logic        gr_wr_req = 1'b0;
   logic        gr_wr_commit;
   logic [5:0]  qp_arch = '0;
   logic        qp_val;
   logic [5:0]  pr_rd_arch = '0;
   logic        pr_rd_val;
   logic        pw_en = 1'b0;
   logic [5:0]  pw_arch = '0;
   logic        pw_data = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int mbase = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rr_rename dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rotate(rotate), .gr_size(gr_size),
      .gr_rd_arch(gr_rd_arch), .gr_rd_phys(gr_rd_phys),
      .gr_wr_arch(gr_wr_arch), .gr_wr_phys(gr_wr_phys),
      .gr_wr_req(gr_wr_req), .gr_wr_commit(gr_wr_commit),
      .qp_arch(qp_arch), .qp_val(qp_val),
      .pr_rd_arch(pr_rd_arch), .pr_rd_val(pr_rd_val),
      .pw_en(pw_en), .pw_arch(pw_arch), .pw_data(pw_data)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int esize();
      return (gr_size > 7'd96) ? 96 : int'(gr_size);
   endfunction

   function automatic int exp_gr(input int a);
      int es = esize();
      int eb = (mbase >= es) ? 0 : mbase;
      if (es == 0 || a < 32 || a >= 32 + es) return a;
      return 32 + ((a - 32 + eb) % es);
   endfunction

   // one clock edge with the given rotate/clear, model updated to match
   task automatic step(input bit rot, input bit c);
      int es = esize();
      rotate = rot; clr = c;
      @(posedge clk);
      if (c) mbase = 0;
      else if (rot) begin
         if (es == 0) mbase = 0;
         else if (mbase == 0 || mbase >= es) mbase = es - 1;
         else mbase = mbase - 1;
      end
      @(negedge clk);
      rotate = 1'b0; clr = 1'b0;
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < 128; a++) begin
         gr_rd_arch = {7'(127 - a), 7'(a)};
         gr_wr_arch = 7'(a);
         #1;
         check(req, int'(gr_rd_phys[6:0]), exp_gr(a));
         check(req, int'(gr_rd_phys[13:7]), exp_gr(127 - a));
         check(req, int'(gr_wr_phys), exp_gr(a));
      end
   endtask

   task automatic pread(input int p, input int exp, input string req);
      pr_rd_arch = 6'(p);
      #1;
      check(req, int'(pr_rd_val), exp);
   endtask

   task automatic pwrite(input int p, input bit d, input int q, input bit rot);
      pw_en = 1'b1; pw_arch = 6'(p); pw_data = d; qp_arch = 6'(q);
      step(rot, 1'b0);
      pw_en = 1'b0; qp_arch = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int sizes[8] = '{0, 1, 2, 3, 7, 50, 96, 127};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state, identity mapping and cleared predicates
      sweep("R10 reset mapping");
      for (int p = 0; p < 64; p++) pread(p, (p == 0) ? 1 : 0, "R10 reset predicate");

      // R1 R2 R3 R4: size sweep over more than one full rotation
      foreach (sizes[k]) begin
         gr_size = 7'(sizes[k]);
         step(1'b0, 1'b1);
         for (int r = 0; r < esize() + 2; r++) begin
            sweep((sizes[k] == 0) ? "R4 size zero" : "R2 R3 rotation");
            step(1'b1, 1'b0);
         end
         sweep((sizes[k] == 0) ? "R4 size zero" : "R2 R3 rotation");
      end

      // R5: clear wins over a same-cycle rotate
      gr_size = 7'd20;
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      sweep("R5 clear priority");

      // R3: stored base left outside a shrunken region counts as zero
      gr_size = 7'd10;
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      gr_size = 7'd5;
      sweep("R3 shrunk region");
      step(1'b1, 1'b0);
      sweep("R3 step from out-of-range base");

      // R9: before the edge the write index still uses the old base
      gr_size = 7'd8;
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      gr_wr_arch = 7'd32;
      rotate = 1'b1;
      #1;
      check("R9 general write before rotate", int'(gr_wr_phys), 39);
      rotate = 1'b0;

      // predicate tests start from a cleared base
      gr_size = 7'd96;
      step(1'b0, 1'b1);
      pwrite(5, 1'b1, 0, 1'b0);
      pread(5, 1, "R8 commit under p0");
      pwrite(0, 1'b0, 0, 1'b0);
      pread(0, 1, "R7 write to p0 ignored");
      qp_arch = 6'd0; #1;
      check("R7 qualifying p0", int'(qp_val), 1);
      pwrite(9, 1'b1, 7, 1'b0);
      pread(9, 0, "R8 suppressed predicate write");
      gr_wr_req = 1'b1;
      qp_arch = 6'd7; #1;
      check("R8 general commit suppressed", int'(gr_wr_commit), 0);
      qp_arch = 6'd5; #1;
      check("R8 general commit taken", int'(gr_wr_commit), 1);
      gr_wr_req = 1'b0; #1;
      check("R8 no request no commit", int'(gr_wr_commit), 0);
      qp_arch = 6'd0;

      // R6: rotating predicates shift, static ones do not
      pwrite(16, 1'b1, 0, 1'b0);
      pwrite(15, 1'b1, 0, 1'b0);
      step(1'b1, 1'b0);
      pread(17, 1, "R6 p16 seen as p17");
      pread(16, 0, "R6 p16 after rotate");
      pread(15, 1, "R6 static p15");
      pread(5, 1, "R6 static p5");

      // R9: predicate write together with rotate uses old mapping
      pwrite(20, 1'b1, 0, 1'b1);
      pread(21, 1, "R9 predicate write with rotate");
      pread(20, 0, "R9 predicate old number empty");
      pread(18, 1, "R6 earlier p16 after two steps");

      // R6: 48 steps bring the region back
      for (int r = 0; r < 46; r++) step(1'b1, 1'b0);
      pread(16, 1, "R6 full predicate wrap");
      pread(19, 1, "R6 full predicate wrap second");

      // R5: clear restores predicate base
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      pread(16, 1, "R5 predicate clear");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule